// File: doc/BRIEF.md
# Four-Channel PWM Configuration Register Bank

This block is the software-visible configuration store of a four-channel pulse-width modulator. A host issues single 32-bit word accesses into a 4 KiB address window. Writes update the shared and per-channel settings. Reads return the stored values one cycle later. Each channel's counter logic receives its settings as already decoded fields: prescaler, clock selection, enable, output inversion, toggle (continuous) mode, period and compare. It never has to unpack the shared words itself.

Every request is a one-cycle pulse on `bus_valid`, with `bus_write` choosing the direction. The block has no back-pressure. It accepts a request in every cycle, and it returns read data exactly one cycle after a read request with `bus_rvalid` set. The period and compare values are 16 bits wide, and larger writes saturate. The per-channel data registers can only be read. The interrupt and watchdog-data locations are placeholders that read as zero. A read of any other location, including a misaligned one, returns zero and reports an error.

Top module: `pwmrb_regbank`

## Requirements
- R1: After reset, every readable location returns zero and every decoded channel output is zero.
- R2: Word offsets are as follows. Prescaler word is 0x00, clock-select word is 0x04, control word is 0x08. For channel n (0..3): period is 0x0C+12n, compare is 0x10+12n, data is 0x14+12n. Interrupt enable is 0x3C, interrupt status is 0x40, watchdog data n is 0x44+4n. The address is a byte address, and data is little-endian with bit 0 as the least significant bit.
- R3: A read request in cycle t makes `bus_rvalid` high in cycle t+1 only, with `bus_rdata` valid in that cycle. `bus_rvalid` is low in any cycle that does not follow a read request.
- R4: A write of a value above 65535 to a period or compare location stores 65535. Any smaller value is stored unchanged and reads back as written.
- R5: The per-channel data locations read as zero, and writes to them change no readable value and no output.
- R6: The interrupt-enable, interrupt-status and four watchdog-data locations read as zero and do not raise the error flag. Writes to them change nothing.
- R7: The prescaler, clock-select and control words store all 32 written bits and read them back unchanged.
- R8: Decoded fields are taken from fixed bit positions. The prescaler for channels 0 and 1 is bits 7:0, and for channels 2 and 3 it is bits 15:8. The clock select for channel n is bits 4n+2:4n. The control nibble base is bit 0, 8, 12 or 16 for channels 0 to 3. Within the nibble, bit 0 is enable, bit 2 is invert and bit 3 is toggle mode.
- R9: A read of an offset not listed in R2, or of an offset with either low address bit set, returns zero and sets `bus_err` for that read's response cycle only. A write to such an offset is dropped.
- R10: Decoded channel outputs change only in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one access per high cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Undecoded or misaligned read response |
| ch_prescale | output | 32 | Per-channel 8-bit prescaler, channel n at bits 8n+7:8n |
| ch_clksel | output | 12 | Per-channel 3-bit clock select, channel n at bits 3n+2:3n |
| ch_enable | output | 4 | Per-channel enable |
| ch_invert | output | 4 | Per-channel output inversion |
| ch_toggle | output | 4 | Per-channel continuous (toggle) mode |
| ch_period | output | 64 | Per-channel 16-bit period, channel n at bits 16n+15:16n |
| ch_compare | output | 64 | Per-channel 16-bit compare, channel n at bits 16n+15:16n |

## Verification
The bench builds the block with its defaults: a 12-bit address and 16-bit counter fields. With a 12-bit address, random addresses cover the full 4 KiB window, including every misaligned and undecoded offset. With 16-bit fields, directed writes of 65535, 65536 and 0xFFFFFFFF sit on both sides of the saturation point. Random control words exercise the irregular nibble positions and the shared prescaler bytes, and a bench model predicts every read and every decoded field.

// File: rtl/pwmrb_pkg.sv
package pwmrb_pkg;
  localparam int NUM_CH    = 4;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int DATA_W    = 32;
  localparam int PRESC_W   = 8;
  localparam int CSEL_W    = 3;
  // word offsets; the channel block layout is decoded by neighbours
  localparam int OFF_PRESC  = 'h00;
  localparam int OFF_CSEL   = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_CH     = 'h0C;
  localparam int CH_STRIDE  = 12;
  localparam int OFF_IEN    = OFF_CH + CH_STRIDE * NUM_CH;
  localparam int OFF_ISTAT  = OFF_IEN + 4;
  localparam int OFF_WDOG   = OFF_ISTAT + 4;

  typedef enum logic [3:0] {
    K_NONE, K_PRESC, K_CSEL, K_CTRL, K_PERIOD, K_COMPARE,
    K_DATA, K_IEN, K_ISTAT, K_WDOG
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [CH_W-1:0]   ch;
  } dec_t;

  // bit bases of per-channel fields inside shared words
  function automatic int presc_base(int i);
    return PRESC_W * (i / 2);
  endfunction
  function automatic int csel_base(int i);
    return 4 * i;
  endfunction
  function automatic int ctrl_base(int i);
    return (i == 0) ? 0 : 4 + 4 * i;
  endfunction
endpackage

// File: rtl/pwmrb_decode.sv
module pwmrb_decode
  import pwmrb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  always_comb begin
    dec.kind = K_NONE;
    dec.ch   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFF_PRESC))      dec.kind = K_PRESC;
      else if (addr == ADDR_W'(OFF_CSEL))  dec.kind = K_CSEL;
      else if (addr == ADDR_W'(OFF_CTRL))  dec.kind = K_CTRL;
      else if (addr == ADDR_W'(OFF_IEN))   dec.kind = K_IEN;
      else if (addr == ADDR_W'(OFF_ISTAT)) dec.kind = K_ISTAT;
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(OFF_CH + CH_STRIDE * i)) begin
          dec.kind = K_PERIOD;  dec.ch = CH_W'(i);
        end
        if (addr == ADDR_W'(OFF_CH + CH_STRIDE * i + 4)) begin
          dec.kind = K_COMPARE; dec.ch = CH_W'(i);
        end
        if (addr == ADDR_W'(OFF_CH + CH_STRIDE * i + 8)) begin
          dec.kind = K_DATA;    dec.ch = CH_W'(i);
        end
        if (addr == ADDR_W'(OFF_WDOG + 4 * i)) begin
          dec.kind = K_WDOG;    dec.ch = CH_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/pwmrb_chan_regs.sv
module pwmrb_chan_regs
  import pwmrb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_period,
  input  logic              wr_compare,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  compare
);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [DATA_W-1:0] CNT_MAX_EXT = DATA_W'(CNT_MAX);

  logic [CNT_W-1:0] clamped;
  assign clamped = (wdata > CNT_MAX_EXT) ? CNT_MAX : wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '0;
      compare <= '0;
    end else begin
      if (wr_period)  period  <= clamped;
      if (wr_compare) compare <= clamped;
    end
  end
endmodule

// File: rtl/pwmrb_fields.sv
module pwmrb_fields
  import pwmrb_pkg::*;
(
  input  logic [DATA_W-1:0]         presc_word,
  input  logic [DATA_W-1:0]         csel_word,
  input  logic [DATA_W-1:0]         ctrl_word,
  output logic [NUM_CH*PRESC_W-1:0] ch_prescale,
  output logic [NUM_CH*CSEL_W-1:0]  ch_clksel,
  output logic [NUM_CH-1:0]         ch_enable,
  output logic [NUM_CH-1:0]         ch_invert,
  output logic [NUM_CH-1:0]         ch_toggle
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int PB = presc_base(g);
    localparam int SB = csel_base(g);
    localparam int CB = ctrl_base(g);
    assign ch_prescale[g*PRESC_W +: PRESC_W] = presc_word[PB +: PRESC_W];
    assign ch_clksel[g*CSEL_W +: CSEL_W]     = csel_word[SB +: CSEL_W];
    assign ch_enable[g] = ctrl_word[CB];
    assign ch_invert[g] = ctrl_word[CB + 2];
    assign ch_toggle[g] = ctrl_word[CB + 3];
  end
endmodule

// File: rtl/pwmrb_regbank.sv
module pwmrb_regbank
  import pwmrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      bus_rvalid,
  output logic                      bus_err,
  output logic [NUM_CH*PRESC_W-1:0] ch_prescale,
  output logic [NUM_CH*CSEL_W-1:0]  ch_clksel,
  output logic [NUM_CH-1:0]         ch_enable,
  output logic [NUM_CH-1:0]         ch_invert,
  output logic [NUM_CH-1:0]         ch_toggle,
  output logic [NUM_CH*CNT_W-1:0]   ch_period,
  output logic [NUM_CH*CNT_W-1:0]   ch_compare
);
  dec_t dec;
  logic wr_en, rd_en;
  logic [DATA_W-1:0] presc_q, csel_q, ctrl_q;
  logic [CNT_W-1:0]  per_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic              rd_bad;

  assign wr_en = bus_valid &&  bus_write;
  assign rd_en = bus_valid && !bus_write;

  pwmrb_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .dec(dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      csel_q  <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      if (dec.kind == K_PRESC) presc_q <= bus_wdata;
      if (dec.kind == K_CSEL)  csel_q  <= bus_wdata;
      if (dec.kind == K_CTRL)  ctrl_q  <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwmrb_chan_regs #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_period (wr_en && dec.kind == K_PERIOD  && dec.ch == CH_W'(g)),
      .wr_compare(wr_en && dec.kind == K_COMPARE && dec.ch == CH_W'(g)),
      .wdata     (bus_wdata),
      .period    (per_q[g]),
      .compare   (cmp_q[g])
    );
    assign ch_period[g*CNT_W +: CNT_W]  = per_q[g];
    assign ch_compare[g*CNT_W +: CNT_W] = cmp_q[g];
  end

  pwmrb_fields u_fields (
    .presc_word (presc_q),
    .csel_word  (csel_q),
    .ctrl_word  (ctrl_q),
    .ch_prescale(ch_prescale),
    .ch_clksel  (ch_clksel),
    .ch_enable  (ch_enable),
    .ch_invert  (ch_invert),
    .ch_toggle  (ch_toggle)
  );

  always_comb begin
    rd_mux = '0;
    rd_bad = 1'b0;
    case (dec.kind)
      K_PRESC:   rd_mux = presc_q;
      K_CSEL:    rd_mux = csel_q;
      K_CTRL:    rd_mux = ctrl_q;
      K_PERIOD:  rd_mux = DATA_W'(per_q[dec.ch]);
      K_COMPARE: rd_mux = DATA_W'(cmp_q[dec.ch]);
      K_NONE:    rd_bad = 1'b1;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      bus_err    <= rd_en && rd_bad;
      bus_rdata  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pwmrb_regbank_chk.sv
module pwmrb_regbank_chk
  import pwmrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic                      bus_rvalid,
  input logic                      bus_err,
  input logic [NUM_CH*PRESC_W-1:0] ch_prescale,
  input logic [NUM_CH*CSEL_W-1:0]  ch_clksel,
  input logic [NUM_CH-1:0]         ch_enable,
  input logic [NUM_CH-1:0]         ch_invert,
  input logic [NUM_CH-1:0]         ch_toggle,
  input logic [NUM_CH*CNT_W-1:0]   ch_period,
  input logic [NUM_CH*CNT_W-1:0]   ch_compare
);
  localparam logic [DATA_W-1:0] MAX_EXT = DATA_W'({CNT_W{1'b1}});

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid); // R3
  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid); // R3
  AST_ERR_WITH_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rvalid && bus_rdata == '0)); // R9
  AST_PERIOD0_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(OFF_CH) && bus_wdata > MAX_EXT)
    |=> ch_period[CNT_W-1:0] == {CNT_W{1'b1}}); // R4
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> ($stable(ch_prescale) && $stable(ch_clksel) &&
      $stable(ch_enable) && $stable(ch_invert) && $stable(ch_toggle) &&
      $stable(ch_period) && $stable(ch_compare))); // R10
endmodule

bind pwmrb_regbank pwmrb_regbank_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .bus_err(bus_err), .ch_prescale(ch_prescale),
  .ch_clksel(ch_clksel), .ch_enable(ch_enable), .ch_invert(ch_invert),
  .ch_toggle(ch_toggle), .ch_period(ch_period), .ch_compare(ch_compare)
);

// File: tb/pwmrb_regbank_test.sv
module pwmrb_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int CW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid, bus_err;
  logic [31:0]   ch_prescale;
  logic [11:0]   ch_clksel;
  logic [3:0]    ch_enable, ch_invert, ch_toggle;
  logic [63:0]   ch_period, ch_compare;

  int checks = 0, fails = 0;
  logic [31:0] m_presc = 0, m_csel = 0, m_ctrl = 0;
  logic [15:0] m_per [4];
  logic [15:0] m_cmp [4];

  pwmrb_regbank #(.ADDR_W(AW), .CNT_W(CW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of the read side (R2, R5, R6, R7, R9)
  function automatic logic [32:0] exp_read(input logic [AW-1:0] a);
    int r;
    if (a[1:0] != 0) return {1'b1, 32'h0};
    if (a == 12'h000) return {1'b0, m_presc};
    if (a == 12'h004) return {1'b0, m_csel};
    if (a == 12'h008) return {1'b0, m_ctrl};
    if (a >= 12'h00C && a < 12'h03C) begin
      r = int'(a) - 12;
      case (r % 12)
        0: return {1'b0, 16'h0, m_per[r/12]};
        4: return {1'b0, 16'h0, m_cmp[r/12]};
        default: return {1'b0, 32'h0};
      endcase
    end
    if (a >= 12'h03C && a <= 12'h050) return {1'b0, 32'h0};
    return {1'b1, 32'h0};
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int r;
    logic [15:0] c;
    c = (d > 32'hFFFF) ? 16'hFFFF : d[15:0];
    if (a == 12'h000) m_presc = d;
    else if (a == 12'h004) m_csel = d;
    else if (a == 12'h008) m_ctrl = d;
    else if (a >= 12'h00C && a < 12'h03C && a[1:0] == 0) begin
      r = int'(a) - 12;
      if (r % 12 == 0) m_per[r/12] = c;
      else if (r % 12 == 4) m_cmp[r/12] = c;
    end
  endfunction

  task automatic check_fields(input string req);
    for (int i = 0; i < 4; i++) begin
      int cb;
      cb = (i == 0) ? 0 : 4 + 4 * i;
      check({req, " R8 prescale"}, ch_prescale[i*8 +: 8], m_presc[8*(i/2) +: 8]);
      check({req, " R8 clksel"}, ch_clksel[i*3 +: 3], m_csel[4*i +: 3]);
      check({req, " R8 enable"}, ch_enable[i], m_ctrl[cb]);
      check({req, " R8 invert"}, ch_invert[i], m_ctrl[cb+2]);
      check({req, " R8 toggle"}, ch_toggle[i], m_ctrl[cb+3]);
      check({req, " R4 period"}, ch_period[i*16 +: 16], m_per[i]);
      check({req, " R4 compare"}, ch_compare[i*16 +: 16], m_cmp[i]);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    model_write(a, d);
    check({req, " R3 no rvalid on write"}, bus_rvalid, 1'b0);
    check_fields(req);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [32:0] e;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    e = exp_read(a);
    check({req, " R3 rvalid"}, bus_rvalid, 1'b1);
    check({req, " R9 err"}, bus_err, e[32]);
    check({req, " rdata"}, bus_rdata, e[31:0]);
    @(negedge clk);
    check({req, " R3 rvalid one cycle"}, bus_rvalid, 1'b0);
  endtask

  initial begin
    logic [AW-1:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_per[i] = 0; m_cmp[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", bus_rvalid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check_fields("R1 reset");
    for (int o = 0; o <= 'h50; o += 4) do_read(AW'(o), "R1 R2 reset read");

    // directed saturation corners (R4)
    do_write(12'h00C, 32'd65535, "R4 max");
    do_read(12'h00C, "R4 max readback");
    do_write(12'h018, 32'd65536, "R4 just above");
    do_read(12'h018, "R4 just above readback");
    do_write(12'h034, 32'hFFFF_FFFF, "R4 all ones cmp3");
    do_read(12'h034, "R4 cmp3 readback");
    do_write(12'h010, 32'd1234, "R4 plain cmp0");
    do_read(12'h010, "R4 plain readback");

    // R7 full-word shared registers, R8 irregular fields
    do_write(12'h000, 32'hA5C3_7E19, "R7 presc");
    do_write(12'h004, 32'h8765_4321, "R7 csel");
    do_write(12'h008, 32'h000D_D0DD, "R8 ctrl mix");
    do_read(12'h008, "R7 ctrl readback");
    do_write(12'h008, 32'hFFFF_FFFF, "R8 ctrl all");
    do_read(12'h000, "R7 presc readback");

    // R5 data locations, R6 placeholders, R9 dropped writes
    do_write(12'h014, 32'hDEAD_BEEF, "R5 data write");
    do_read(12'h014, "R5 data read");
    do_write(12'h03C, 32'hFFFF_FFFF, "R6 ien write");
    do_write(12'h040, 32'hFFFF_FFFF, "R6 istat write");
    do_write(12'h04C, 32'hFFFF_FFFF, "R6 wdog write");
    do_read(12'h040, "R6 istat read");
    do_read(12'h04C, "R6 wdog read");
    do_write(12'h00D, 32'h1, "R9 misaligned write");
    do_read(12'h00E, "R9 misaligned read");
    do_write(12'h800, 32'h1, "R9 undecoded write");
    do_read(12'h054, "R9 undecoded read");
    do_read(12'hFFC, "R9 top read");

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      case ($urandom_range(0, 3))
        0: a = AW'($urandom_range(0, 4095));
        default: a = AW'($urandom_range(0, 20) * 4);
      endcase
      case ($urandom_range(0, 2))
        0: d = $urandom_range(0, 65535);
        1: d = 32'h1_0000 + $urandom_range(0, 255);
        default: d = $urandom;
      endcase
      if ($urandom_range(0, 1) == 1) do_write(a, d, "R10 random write");
      else do_read(a, "R2 random read");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule